// File: doc/BRIEF.md
# Five-Channel Output Compare Unit

This block watches a free-running 16-bit counter that lives elsewhere and reports when it reaches any of five programmed values. Each channel holds a 16-bit compare value. On every prescaled counter tick, each enabled channel whose value equals the counter exactly sets its bit in a flag byte. An interrupt request is raised while any flagged channel is also enabled.

Software reaches the block through a byte-wide register port. Ten bytes hold the compare values, each channel as a high byte followed by a low byte. One byte holds the per-channel enables, and one byte holds the flags, which are cleared by writing ones. The counter value and its tick strobe come from the timer that owns the counter. Driving pins on a match, forced compares and input capture are handled elsewhere.

Top module: `ocu_top`

## Requirements
- R1: After reset all compare values, the enable byte and the flag byte read zero, and the interrupt request is low.
- R2: Channel k (k = 0..4) keeps its compare value at byte address 2k (bits 15:8) and 2k+1 (bits 7:0). A write stores the byte, a read returns it on the same cycle as the address, and bytes that are not written keep their value.
- R3: The enable byte is at address 10 and the flag byte at address 11. Channel k uses bit 7-k in both, so the channels take bits 7 down to 3. Bits 2:0 always read zero. Writes to addresses 12 to 15 change nothing, and reads there return zero.
- R4: On a cycle with the tick high, a channel whose compare value equals the counter exactly, and whose enable bit is set, has its flag set from the next cycle. A channel that is not enabled, or that does not match, gets no flag.
- R5: When several enabled channels match on the same tick, all of their flags are set together.
- R6: Matching is suppressed while enable bits 7:4 are all zero. A match on channel 4 alone, with only bit 3 enabled, sets no flag.
- R7: No flag is set on a cycle without a tick. A counter value held equal to a compare value across several cycles with a single tick sets the flag once, and a flag cleared while that value is still held stays clear.
- R8: A compare byte or enable written on a tick cycle takes part in matching from the next tick. The match on the write cycle uses the old contents.
- R9: Writing the flag byte clears each bit written as 1 and leaves each bit written as 0. A flag being set on the same cycle that software clears it ends up set.
- R10: The interrupt request is high exactly when some flag bit and the enable bit at the same position are both 1. Clearing an enable drops the request without clearing the flag.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle strobe: the counter advanced, evaluate matches |
| cnt_i | input | 16 | Current free-running counter value |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 4 | Register byte address for reads and writes |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data for addr_i, combinational |
| flags_o | output | 8 | Flag byte, channel k at bit 7-k |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong compare byte, or a lost write, shows up at the ports as soon as the address is read back. It also shows up on the first tick whose counter value should have matched, when the flag byte fails to change one cycle later. A bad enable or flag register shows on flags_o, and on irq_o in the same cycle as the register changes, because the request is a combination of registered state with no added delay. The gating on the upper four enables and the old-value-on-write-cycle rule can only be seen on a tick, so the bench lines up ticks with writes and with enable patterns that use channel 4 alone.

// File: rtl/ocu_pkg.sv
package ocu_pkg;

   // Kind of register selected by a byte address.
   typedef enum logic [1:0] {
      OCU_NONE = 2'd0,
      OCU_CMP  = 2'd1,
      OCU_MASK = 2'd2,
      OCU_FLAG = 2'd3
   } ocu_kind_e;

   // Bit of the enable/flag byte that belongs to a channel: first channel at the top.
   function automatic int chan_bit(input int data_w, input int chan);
      return data_w - 1 - chan;
   endfunction

endpackage

// File: rtl/ocu_addr_dec.sv
module ocu_addr_dec
   import ocu_pkg::*;
#(
   parameter int NUM_CH = 5,
   parameter int BPC    = 2,
   parameter int ADDR_W = 4
) (
   input  logic [ADDR_W-1:0]     addr_i,
   output logic [NUM_CH*BPC-1:0] byte_sel_o,
   output ocu_kind_e             kind_o
);

   localparam int N_BYTES   = NUM_CH * BPC;
   localparam int MASK_ADDR = N_BYTES;
   localparam int FLAG_ADDR = N_BYTES + 1;

   if (FLAG_ADDR >= (1 << ADDR_W)) begin : g_bad_addr_w
      $error("ocu_addr_dec: ADDR_W too small for the register map");
   end

   always_comb begin
      byte_sel_o = '0;
      kind_o     = OCU_NONE;
      for (int i = 0; i < N_BYTES; i++) begin
         if (addr_i == ADDR_W'(i)) begin
            byte_sel_o[i] = 1'b1;
            kind_o        = OCU_CMP;
         end
      end
      if (addr_i == ADDR_W'(MASK_ADDR)) kind_o = OCU_MASK;
      if (addr_i == ADDR_W'(FLAG_ADDR)) kind_o = OCU_FLAG;
   end

endmodule

// File: rtl/ocu_cmp_chan.sv
module ocu_cmp_chan #(
   parameter int CNT_W  = 16,
   parameter int DATA_W = 8
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic [CNT_W/DATA_W-1:0] wr_byte_i,
   input  logic [DATA_W-1:0]       wdata_i,
   input  logic                    tick_i,
   input  logic [CNT_W-1:0]        cnt_i,
   output logic                    hit_o,
   output logic [CNT_W-1:0]        value_o
);

   localparam int BPC = CNT_W / DATA_W;

   if (CNT_W % DATA_W != 0) begin : g_bad_split
      $error("ocu_cmp_chan: CNT_W must be a multiple of DATA_W");
   end

   // Byte 0 is the most significant byte and sits at the lower address.
   logic [DATA_W-1:0] byte_q [BPC];

   for (genvar j = 0; j < BPC; j++) begin : g_byte
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            byte_q[j] <= '0;
         else if (wr_byte_i[j])
            byte_q[j] <= wdata_i;
      end
   end

   always_comb begin
      value_o = '0;
      for (int j = 0; j < BPC; j++)
         value_o[CNT_W-1-j*DATA_W -: DATA_W] = byte_q[j];
   end

   // Registered value is compared, so a write lands for the next tick.
   assign hit_o = tick_i && (value_o == cnt_i);

   // R2: bytes that are not written hold their value
   a_r2_value_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_byte_i == '0) |=> $stable(value_o));

endmodule

// File: rtl/ocu_flag_bank.sv
module ocu_flag_bank
   import ocu_pkg::*;
#(
   parameter int NUM_CH  = 5,
   parameter int DATA_W  = 8,
   parameter int GATE_CH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NUM_CH-1:0] hit_i,
   input  logic              mask_we_i,
   input  logic              flag_we_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] mask_byte_o,
   output logic [DATA_W-1:0] flag_byte_o,
   output logic              irq_o
);

   if (NUM_CH > DATA_W) begin : g_bad_num_ch
      $error("ocu_flag_bank: more channels than bits in a register byte");
   end
   if (GATE_CH > NUM_CH || GATE_CH < 0) begin : g_bad_gate
      $error("ocu_flag_bank: GATE_CH out of range");
   end

   logic [NUM_CH-1:0] en_q, fl_q, wr_bits, set_v, clr_v, fl_d;
   logic              gate;

   // Channel k of the register byte lives at bit DATA_W-1-k.
   for (genvar k = 0; k < NUM_CH; k++) begin : g_bits
      assign wr_bits[k] = wdata_i[chan_bit(DATA_W, k)];
   end

   if (NUM_CH < DATA_W) begin : g_spare
      logic unused_low;
      assign unused_low = ^wdata_i[DATA_W-NUM_CH-1:0];
   end

   // Matching runs only while one of the first GATE_CH enables is set.
   if (GATE_CH == 0) begin : g_nogate
      assign gate = 1'b1;
   end else begin : g_gate
      assign gate = |en_q[GATE_CH-1:0];
   end

   assign set_v = hit_i & en_q & {NUM_CH{gate}};
   assign clr_v = flag_we_i ? wr_bits : '0;
   assign fl_d  = (fl_q & ~clr_v) | set_v;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= '0;
         fl_q <= '0;
      end else begin
         fl_q <= fl_d;
         if (mask_we_i)
            en_q <= wr_bits;
      end
   end

   always_comb begin
      mask_byte_o = '0;
      flag_byte_o = '0;
      for (int k = 0; k < NUM_CH; k++) begin
         mask_byte_o[chan_bit(DATA_W, k)] = en_q[k];
         flag_byte_o[chan_bit(DATA_W, k)] = fl_q[k];
      end
   end

   assign irq_o = |(fl_q & en_q);

   // R4: a new flag only appears on a channel that was enabled
   a_r4_enabled_only: assert property (@(posedge clk) disable iff (!rst_n)
      (hit_i != '0) |=> ((fl_q & ~$past(fl_q) & ~$past(en_q)) == '0));

   // R9: a written 1 clears its flag unless a set lands on the same cycle
   a_r9_clear_wins_alone: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_we_i && ((hit_i & en_q) == '0)) |=> ((fl_q & $past(wr_bits)) == '0));

   if (GATE_CH > 0) begin : g_gate_chk
      // R6: with the gating enables all clear, no flag is set
      a_r6_gate_off: assert property (@(posedge clk) disable iff (!rst_n)
         (en_q[GATE_CH-1:0] == '0) |=> ((fl_q & ~$past(fl_q)) == '0));
   end

endmodule

// File: rtl/ocu_top.sv
module ocu_top
   import ocu_pkg::*;
#(
   parameter int NUM_CH  = 5,
   parameter int CNT_W   = 16,
   parameter int DATA_W  = 8,
   parameter int ADDR_W  = 4,
   parameter int GATE_CH = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic [CNT_W-1:0]  cnt_i,
   input  logic              wr_en_i,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   output logic [DATA_W-1:0] flags_o,
   output logic              irq_o
);

   localparam int BPC     = CNT_W / DATA_W;
   localparam int N_BYTES = NUM_CH * BPC;

   if (NUM_CH < 1) begin : g_bad_ch
      $error("ocu_top: NUM_CH must be at least 1");
   end

   logic [N_BYTES-1:0] byte_sel;
   ocu_kind_e          kind;
   logic [NUM_CH-1:0]  hit;
   logic [CNT_W-1:0]   ch_val [NUM_CH];
   logic [DATA_W-1:0]  mask_byte, flag_byte;
   logic               cmp_we;

   ocu_addr_dec #(
      .NUM_CH (NUM_CH),
      .BPC    (BPC),
      .ADDR_W (ADDR_W)
   ) u_dec (
      .addr_i     (addr_i),
      .byte_sel_o (byte_sel),
      .kind_o     (kind)
   );

   assign cmp_we = wr_en_i && (kind == OCU_CMP);

   for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
      ocu_cmp_chan #(
         .CNT_W  (CNT_W),
         .DATA_W (DATA_W)
      ) u_chan (
         .clk       (clk),
         .rst_n     (rst_n),
         .wr_byte_i (byte_sel[c*BPC +: BPC] & {BPC{cmp_we}}),
         .wdata_i   (wdata_i),
         .tick_i    (tick_i),
         .cnt_i     (cnt_i),
         .hit_o     (hit[c]),
         .value_o   (ch_val[c])
      );
   end

   ocu_flag_bank #(
      .NUM_CH  (NUM_CH),
      .DATA_W  (DATA_W),
      .GATE_CH (GATE_CH)
   ) u_flags (
      .clk         (clk),
      .rst_n       (rst_n),
      .hit_i       (hit),
      .mask_we_i   (wr_en_i && (kind == OCU_MASK)),
      .flag_we_i   (wr_en_i && (kind == OCU_FLAG)),
      .wdata_i     (wdata_i),
      .mask_byte_o (mask_byte),
      .flag_byte_o (flag_byte),
      .irq_o       (irq_o)
   );

   always_comb begin
      rdata_o = '0;
      case (kind)
         OCU_CMP: begin
            for (int i = 0; i < N_BYTES; i++)
               if (byte_sel[i])
                  rdata_o = ch_val[i / BPC][CNT_W-1-(i % BPC)*DATA_W -: DATA_W];
         end
         OCU_MASK: rdata_o = mask_byte;
         OCU_FLAG: rdata_o = flag_byte;
         default:  rdata_o = '0;
      endcase
   end

   assign flags_o = flag_byte;

   // R7: without a tick no flag bit rises
   a_r7_no_tick_no_set: assert property (@(posedge clk) disable iff (!rst_n)
      !tick_i |=> ((flags_o & ~$past(flags_o)) == '0));

   // R10: the request needs at least one flag
   a_r10_irq_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> (flags_o != '0));

   // R1: first cycle out of reset is quiet
   a_r1_reset_quiet: assert property (@(posedge clk)
      $rose(rst_n) |-> (!irq_o && flags_o == '0));

endmodule

// File: tb/ocu_top_bench.sv
`timescale 1ns/1ps
module ocu_top_bench;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_i = 1'b0;
   logic [15:0] cnt_i = '0;
   logic        wr_en_i = 1'b0;
   logic [3:0]  addr_i = '0;
   logic [7:0]  wdata_i = '0;
   logic [7:0]  rdata_o, flags_o;
   logic        irq_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   // Reference state, built from the requirements
   logic [15:0] m_cmp [5];
   logic [7:0]  m_mask = '0;
   logic [7:0]  m_flags = '0;

   always #2.5 clk = ~clk;

   ocu_top u_ocu_top (
      .clk     (clk),
      .rst_n   (rst_n),
      .tick_i  (tick_i),
      .cnt_i   (cnt_i),
      .wr_en_i (wr_en_i),
      .addr_i  (addr_i),
      .wdata_i (wdata_i),
      .rdata_o (rdata_o),
      .flags_o (flags_o),
      .irq_o   (irq_o)
   );

   function automatic logic [7:0] model_read(input logic [3:0] a);
      if (a < 4'd10)
         return a[0] ? m_cmp[a >> 1][7:0] : m_cmp[a >> 1][15:8];
      else if (a == 4'd10)
         return m_mask & 8'hF8;
      else if (a == 4'd11)
         return m_flags & 8'hF8;
      return 8'h00;
   endfunction

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
      end
   endtask

   // One clock: drive, update the reference on the edge, compare after it.
   task automatic cyc(input logic t, input logic [15:0] c, input logic w,
                      input logic [3:0] a, input logic [7:0] d, input string req);
      logic [7:0] sets, clr;
      tick_i = t; cnt_i = c; wr_en_i = w; addr_i = a; wdata_i = d;
      sets = '0;
      if (t && (m_mask[7:4] != 4'h0))
         for (int k = 0; k < 5; k++)
            if (m_cmp[k] == c && m_mask[7-k]) sets[7-k] = 1'b1;
      clr = (w && a == 4'd11) ? (d & 8'hF8) : 8'h00;
      @(posedge clk);
      m_flags = (m_flags & ~clr) | sets;
      if (w && a < 4'd10) begin
         if (a[0]) m_cmp[a >> 1][7:0] = d;
         else      m_cmp[a >> 1][15:8] = d;
      end
      if (w && a == 4'd10) m_mask = d & 8'hF8;
      #1;
      check({req, " flags"}, {8'h00, flags_o}, {8'h00, m_flags});
      check("R10 irq", {15'h0, irq_o}, {15'h0, |(m_flags & m_mask)});
      check("R2 rdata", {8'h00, rdata_o}, {8'h00, model_read(a)});
   endtask

   task automatic wr(input logic [3:0] a, input logic [7:0] d, input string req);
      cyc(1'b0, 16'h0, 1'b1, a, d, req);
   endtask

   task automatic wr16(input int ch, input logic [15:0] v);
      wr(4'(2*ch), v[15:8], "R2");
      wr(4'(2*ch+1), v[7:0], "R2");
   endtask

   initial begin
      #(5.0 * 150000);
      if (!done) begin
         errors++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("  CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      for (int k = 0; k < 5; k++) m_cmp[k] = '0;
      repeat (3) @(posedge clk);
      #1;
      // R1: reset state at the ports
      check("R1 flags", {8'h00, flags_o}, 16'h0000);
      check("R1 irq", {15'h0, irq_o}, 16'h0000);
      rst_n = 1'b1;
      for (int a = 0; a < 16; a++) cyc(1'b0, 16'h0, 1'b0, 4'(a), 8'h00, "R1");

      // R2: byte placement and readback
      wr16(0, 16'h1234); wr16(1, 16'h5555); wr16(2, 16'h5555);
      wr16(3, 16'hABCD); wr16(4, 16'h7777);
      cyc(1'b0, 16'h0, 1'b0, 4'd0, 8'h00, "R2");
      check("R2 high byte", {8'h00, rdata_o}, 16'h0012);
      cyc(1'b0, 16'h0, 1'b0, 4'd7, 8'h00, "R2");
      check("R2 low byte", {8'h00, rdata_o}, 16'h00CD);

      // R3: enable byte, low bits read zero, unmapped writes ignored
      wr(4'd10, 8'hFF, "R3");
      check("R3 mask low bits", {8'h00, rdata_o}, 16'h00F8);
      wr(4'd13, 8'h99, "R3");
      check("R3 unmapped read", {8'h00, rdata_o}, 16'h0000);
      wr(4'd10, 8'h80, "R3");

      // R4: single enabled match
      cyc(1'b1, 16'h1234, 1'b0, 4'd11, 8'h00, "R4");
      check("R4 flag ch0", {8'h00, flags_o}, 16'h0080);
      check("R10 irq set", {15'h0, irq_o}, 16'h0001);
      cyc(1'b1, 16'hABCD, 1'b0, 4'd11, 8'h00, "R4");  // ch3 disabled

      // R9: write 0 keeps, write 1 clears
      wr(4'd11, 8'h00, "R9");
      wr(4'd11, 8'h80, "R9");
      check("R9 cleared", {8'h00, flags_o}, 16'h0000);

      // R7: value held, one tick then no ticks, clear stays clear
      cyc(1'b1, 16'h1234, 1'b0, 4'd11, 8'h00, "R7");
      cyc(1'b0, 16'h1234, 1'b1, 4'd11, 8'h80, "R7");
      cyc(1'b0, 16'h1234, 1'b0, 4'd11, 8'h00, "R7");
      cyc(1'b0, 16'h1234, 1'b0, 4'd11, 8'h00, "R7");
      check("R7 stays clear", {8'h00, flags_o}, 16'h0000);

      // R5: two channels match together
      wr(4'd10, 8'h60, "R5");
      cyc(1'b1, 16'h5555, 1'b0, 4'd11, 8'h00, "R5");
      check("R5 both flags", {8'h00, flags_o}, 16'h0060);
      wr(4'd11, 8'hFF, "R9");

      // R6: channel 4 alone cannot match
      wr(4'd10, 8'h08, "R6");
      cyc(1'b1, 16'h7777, 1'b0, 4'd11, 8'h00, "R6");
      check("R6 gated", {8'h00, flags_o}, 16'h0000);
      wr(4'd10, 8'h88, "R6");
      cyc(1'b1, 16'h7777, 1'b0, 4'd11, 8'h00, "R6");
      check("R6 ungated", {8'h00, flags_o}, 16'h0008);

      // R10: drop the enable, flag stays
      wr(4'd10, 8'h80, "R10");
      check("R10 irq low", {15'h0, irq_o}, 16'h0000);
      check("R10 flag kept", {8'h00, flags_o}, 16'h0008);
      wr(4'd11, 8'hFF, "R9");

      // R8: write on a tick cycle uses the old value
      cyc(1'b1, 16'h1299, 1'b1, 4'd1, 8'h99, "R8");
      check("R8 old value", {8'h00, flags_o}, 16'h0000);
      cyc(1'b1, 16'h1299, 1'b0, 4'd11, 8'h00, "R8");
      check("R8 new value", {8'h00, flags_o}, 16'h0080);

      // R9: set and clear on one cycle, set wins
      cyc(1'b1, 16'h1299, 1'b1, 4'd11, 8'h80, "R9");
      check("R9 set wins", {8'h00, flags_o}, 16'h0080);

      // Random mix
      for (int n = 0; n < 3000; n++) begin
         logic        t, w;
         logic [15:0] c;
         logic [3:0]  a;
         logic [7:0]  d;
         t = ($urandom % 2) == 0;
         c = (($urandom % 4) == 0) ? 16'($urandom) : m_cmp[$urandom % 5];
         w = ($urandom % 3) == 0;
         a = 4'($urandom);
         d = 8'($urandom);
         if (w && a < 4'd10 && ($urandom % 2) == 0) d = m_cmp[$urandom % 5][7:0];
         cyc(t, c, w, a, d, "R4");
      end

      done = 1'b1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule